// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt Acknowledge

This block is an up-counting interval timer attached to a small register bus. Software programs a terminal value and a starting count; the counter then advances by one on each clock until it equals the terminal value, after which it returns to zero and continues. On that return the block can latch an interrupt-pending flag, and it drives an interrupt line while the flag and the interrupt enable are both set.

A control write both reprograms the two writable control bits and acknowledges any pending interrupt. A halt-aware mode freezes the counter while the processor is halted, so delays measure only run time. With the terminal value at the all-ones maximum and interrupts off, the counter is a free-running wrap-around time base. A one-shot style delay is armed by writing the terminal value, then a zero count, then the control bits.

Top module: `pit_timer`

## Requirements
- R1: While reset is held, count reads 0, the terminal value reads all ones, control reads 0 and irq is low.
- R2: Bus address 0 selects count, 1 selects control, 2 selects the terminal value, and address 3 reads as zero; read data is combinational from the current register state.
- R3: When running, the count increases by exactly one per clock.
- R4: On an advancing clock where count equals the terminal value, the count becomes 0 after that edge.
- R5: The pending flag (control bit 3) is set on that wrap only if interrupt enable (control bit 0) is 1; irq is high exactly when pending and enable are both 1.
- R6: A control write updates only enable (bit 0) and halt-aware mode (bit 1) and clears pending; bit 2 and bits 4 and above always read 0.
- R7: With halt-aware mode (bit 1) set and cpu_halted high, the count holds and no wrap or pending occurs; with bit 1 clear, cpu_halted has no effect.
- R8: A count write loads the written value in place of the increment of the same cycle, and suppresses a wrap in that cycle.
- R9: When a wrap with enable set coincides with a control write, pending ends up set (the new event outranks the acknowledge).
- R10: With the terminal value at all ones and enable clear, the count passes the maximum, wraps to 0 and pending stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| cpu_halted | input | 1 | High while the processor is halted |
| irq | output | 1 | Interrupt request |

## Verification
Every register write, count step, wrap and pending change lands on the rising edge where its stimulus is sampled, so each result is due one clock after the inputs are presented, and irq follows combinationally from the registers of that same edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and reads back half a clock period later, so each expected value accounts for exactly one step of counting. Expected counts in the vector table are advanced by hand one per cycle, with halted cycles, count writes and wraps worked out from the requirements.

// File: rtl/pit_pkg.sv
// pit_pkg: shared register selects and control bit positions for the timer.
// Assumes a two-bit register address on the bus.
package pit_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int BIT_IE   = 0;
    localparam int BIT_NH   = 1;
    localparam int BIT_PEND = 3;
endpackage

// File: rtl/pit_counter.sv
// pit_counter: holds count and terminal value, steps the count and flags wraps.
// Assumes run is already qualified by halt mode; a count write wins over stepping.
module pit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LIM_RST = '1;

    // wrap: an advancing cycle at the terminal value, not overridden by a write
    assign wrap = run && !cnt_we && (count == limit);

    // count register: write, wrap to zero, or step by one
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cnt_we)
            count <= wdata;
        else if (wrap)
            count <= '0;
        else if (run)
            count <= count + 1'b1;
    end

    // terminal value register
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= LIM_RST;
        else if (lim_we)
            limit <= wdata;
    end

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && count == limit) |=> (count == '0));
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(wdata)));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_we && count != limit) |=> (count == $past(count) + 1'b1));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(count));
endmodule

// File: rtl/pit_ctrl.sv
// pit_ctrl: control bits, pending flag and interrupt output.
// Assumes wrap comes from the counter; a wrap outranks a same-cycle acknowledge.
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    input  logic             cpu_halted,
    output logic             ie,
    output logic             nh,
    output logic             pend,
    output logic             run,
    output logic             irq
);
    // run: counting allowed unless halt-aware mode sees a halted processor
    assign run = !(nh && cpu_halted);
    // irq: pending qualified by enable
    assign irq = pend && ie;

    // writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0;
            nh <= 1'b0;
        end else if (ctl_we) begin
            ie <= wdata[BIT_IE];
            nh <= wdata[BIT_NH];
        end
    end

    // pending flag: set by an enabled wrap, cleared by any control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (wrap && ie)
            pend <= 1'b1;
        else if (ctl_we)
            pend <= 1'b0;
    end

    assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(wrap && ie));
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !(wrap && ie)) |=> !pend);
    assert_wrap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ie) |=> pend);
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie && pend));
endmodule

// File: rtl/pit_timer.sv
// pit_timer: top level; decodes bus writes and muxes register reads.
// Assumes single-cycle writes and combinational reads.
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cpu_halted,
    output logic              irq
);
    logic             cnt_we, lim_we, ctl_we;
    logic [CNT_W-1:0] count, limit, ctrl_word;
    logic             wrap, run, ie, nh, pend;

    // write decode
    assign cnt_we = bus_we && (bus_addr == SEL_COUNT);
    assign ctl_we = bus_we && (bus_addr == SEL_CTRL);
    assign lim_we = bus_we && (bus_addr == SEL_LIMIT);

    pit_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .lim_we(lim_we),
        .wdata(bus_wdata), .run(run), .count(count), .limit(limit), .wrap(wrap)
    );

    pit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(bus_wdata),
        .wrap(wrap), .cpu_halted(cpu_halted), .ie(ie), .nh(nh),
        .pend(pend), .run(run), .irq(irq)
    );

    // control word image with reserved bits at zero
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_IE]   = ie;
        ctrl_word[BIT_NH]   = nh;
        ctrl_word[BIT_PEND] = pend;
    end

    // read mux
    always_comb begin
        case (bus_addr)
            SEL_COUNT: bus_rdata = count;
            SEL_CTRL:  bus_rdata = ctrl_word;
            SEL_LIMIT: bus_rdata = limit;
            default:   bus_rdata = '0;
        endcase
    end

    assert_irq_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wrap));
    assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/pit_timer_bench.sv
// pit_timer_bench: vector table walk plus directed corner tests.
module pit_timer_bench;
    localparam int W = 32;

    typedef struct packed {
        logic          we;
        logic [1:0]    waddr;
        logic [W-1:0]  wdata;
        logic          halt;
        logic [1:0]    raddr;
        logic [W-1:0]  exp;
        logic          irq_exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 21;
    // addr 0 count, 1 control, 2 terminal value, 3 unmapped
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 32'd3,          1'b0, 2'd2, 32'd3, 1'b0, 4'd2}, // R2 limit write
        '{1'b1, 2'd0, 32'd0,          1'b0, 2'd0, 32'd0, 1'b0, 4'd8}, // R8 count load
        '{1'b1, 2'd1, 32'd1,          1'b0, 2'd0, 32'd1, 1'b0, 4'd3}, // R3
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd2, 1'b0, 4'd3},
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd3, 1'b0, 4'd3},
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd1, 32'h9, 1'b1, 4'd5}, // R4 R5 wrap sets pending
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd1, 1'b1, 4'd4},
        '{1'b1, 2'd1, 32'd1,          1'b0, 2'd1, 32'd1, 1'b0, 4'd6}, // R6 ack
        '{1'b1, 2'd1, 32'd3,          1'b1, 2'd0, 32'd3, 1'b0, 4'd7}, // R7 old mode still counts
        '{1'b0, 2'd0, 32'd0,          1'b1, 2'd0, 32'd3, 1'b0, 4'd7}, // R7 frozen
        '{1'b0, 2'd0, 32'd0,          1'b1, 2'd0, 32'd3, 1'b0, 4'd7}, // R7 no wrap while frozen
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd1, 32'hB, 1'b1, 4'd7},
        '{1'b1, 2'd1, 32'd0,          1'b0, 2'd1, 32'd0, 1'b0, 4'd6},
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd2, 1'b0, 4'd3},
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd3, 1'b0, 4'd3},
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd0, 1'b0, 4'd4}, // R4 wrap, enable off
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd1, 32'd0, 1'b0, 4'd5}, // R5 no pending
        '{1'b1, 2'd1, 32'hFFFF_FFFF,  1'b0, 2'd1, 32'd3, 1'b0, 4'd6}, // R6 reserved bits
        '{1'b1, 2'd0, 32'd7,          1'b0, 2'd0, 32'd7, 1'b0, 4'd8}, // R8 write wins
        '{1'b0, 2'd0, 32'd0,          1'b0, 2'd0, 32'd8, 1'b0, 4'd3},
        '{1'b1, 2'd2, 32'h100,        1'b0, 2'd3, 32'd0, 1'b0, 4'd2}  // R2 unmapped
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         cpu_halted = 1'b0;
    logic         irq;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    pit_timer #(.CNT_W(W)) u_pit_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_halted(cpu_halted), .irq(irq)
    );

    task automatic check(input int req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] wa, input logic [W-1:0] wd,
                        input logic halt, input logic [1:0] ra);
        @(negedge clk);
        bus_we = we; bus_addr = we ? wa : ra; bus_wdata = wd; cpu_halted = halt;
        @(posedge clk);
        #5;
        bus_we = 1'b0; bus_addr = ra;
        #1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 reset state
        @(negedge clk); bus_addr = 2'd0; #1 check(1, "reset count", bus_rdata, 32'd0);
        bus_addr = 2'd2; #1 check(1, "reset limit", bus_rdata, 32'hFFFF_FFFF);
        bus_addr = 2'd1; #1 check(1, "reset ctrl", bus_rdata, 32'd0);
        check(1, "reset irq", {31'd0, irq}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        bus_addr = 2'd1; bus_wdata = 32'd0;
        // first edge after reset counts 0 -> 1 before the table starts
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].we, VECS[i].waddr, VECS[i].wdata, VECS[i].halt, VECS[i].raddr);
            check(int'(VECS[i].req), $sformatf("vector %0d data", i), bus_rdata, VECS[i].exp);
            check(int'(VECS[i].req), $sformatf("vector %0d irq", i), {31'd0, irq},
                  {31'd0, VECS[i].irq_exp});
        end
        // R10 free-running wrap through the maximum
        step(1'b1, 2'd1, 32'd0, 1'b0, 2'd1);          check(6, "ctrl cleared", bus_rdata, 32'd0);
        step(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 2'd2);  check(10, "max limit", bus_rdata, 32'hFFFF_FFFF);
        step(1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0, 2'd0);  check(10, "near max", bus_rdata, 32'hFFFF_FFFE);
        step(1'b0, 2'd0, 32'd0, 1'b0, 2'd0);          check(10, "at max", bus_rdata, 32'hFFFF_FFFF);
        step(1'b0, 2'd0, 32'd0, 1'b0, 2'd0);          check(10, "wrapped", bus_rdata, 32'd0);
        step(1'b0, 2'd0, 32'd0, 1'b0, 2'd1);          check(10, "no pending", bus_rdata, 32'd0);
        check(10, "irq low", {31'd0, irq}, 32'd0);
        // R9 wrap coinciding with acknowledge
        step(1'b1, 2'd1, 32'd1, 1'b0, 2'd1);          check(6, "enable on", bus_rdata, 32'd1);
        step(1'b1, 2'd2, 32'd5, 1'b0, 2'd2);          check(2, "limit 5", bus_rdata, 32'd5);
        step(1'b1, 2'd0, 32'd4, 1'b0, 2'd0);          check(8, "count 4", bus_rdata, 32'd4);
        step(1'b0, 2'd0, 32'd0, 1'b0, 2'd0);          check(3, "count 5", bus_rdata, 32'd5);
        step(1'b1, 2'd1, 32'd1, 1'b0, 2'd1);          check(9, "wrap beats ack", bus_rdata, 32'h9);
        check(9, "irq held", {31'd0, irq}, 32'd1);
        step(1'b0, 2'd0, 32'd0, 1'b0, 2'd0);          check(4, "after wrap", bus_rdata, 32'd1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule